// File: doc/BRIEF.md
# SWD Access Retry and Fault Controller

This controller turns a single debug-register access request into a finished access on a two-wire serial debug link. It sits between a request/response port and a transaction engine that performs the wire-level packets. For each request it hands one transaction to the engine and classifies the three-bit acknowledge that comes back. From that acknowledge it decides whether to finish, reissue the same transaction, or send a clearing write to the debug port's abort register.

A WAIT acknowledge makes the controller reissue the same transaction until a cycle-count timeout runs out. At timeout it sends an abort that cancels the pending transfer. The first FAULT of an access clears every sticky error flag through the abort register and then retries once. A second FAULT, a missing response, a timeout or a bad read parity sets a sticky fault status. While that status is set, access-port requests are refused at once with no wire activity. Debug-port requests still go through. The status is cleared only by reset.

Top module: `swd_access_ctrl`

## Requirements
- R1: A request is accepted only while `busy` is low, and it produces exactly one engine command with the same access-port flag, direction, address and write data. On acknowledge OK (3'b001), a read responds with the engine's read data, a write responds with data 0, and `rsp_err` is 0. Each response is a single-cycle `rsp_valid` pulse.
- R2: On acknowledge WAIT (3'b010), while the timeout has not expired, the identical command is sent again.
- R3: If a WAIT arrives once `TIMEOUT_CYCLES` clocks have passed since the access was accepted, the controller issues an abort-register write with data 32'h01 (cancel bit, bit 0). The abort-register write is a debug-port write (`eng_cmd_ap`=0, `eng_cmd_rnw`=0) to address 2'b00. After it, the fault status is set and the access responds with `rsp_err`=1 and data 0.
- R4: The first FAULT (3'b100) of an access issues an abort-register write with data 32'h1E. This sets bit 1 (compare clear), bit 2 (error clear), bit 3 (write-data error clear) and bit 4 (overrun clear). The request is then handled as if WAIT had arrived, so it is reissued if the timeout has not expired.
- R5: A FAULT on any later attempt issues the same 32'h1E abort write, sets the fault status, and responds with `rsp_err`=1 and data 0 without a further attempt. Once set, `fault_latched` stays high until reset.
- R6: The no-response acknowledge 3'b111 sets the fault status and responds with `rsp_err`=1 and data 0, with no abort write.
- R7: Any acknowledge other than 001, 010, 100 or 111 responds with `rsp_err`=1, `rsp_proto_err`=1 and data 0, and leaves the fault status unchanged.
- R8: An access-port request (`req_ap`=1) made while `fault_latched` is high responds on the next cycle with `rsp_err`=1 and data 0, and issues no engine command. Debug-port requests are still carried out.
- R9: For an OK read, the received parity bit must equal the XOR of the 32 data bits (even parity). On a mismatch the fault status is set, and the access responds with `rsp_err`=1 and data 0.
- R10: An engine command, once raised, keeps `eng_cmd_valid` and its payload unchanged until it is taken with `eng_cmd_ready`.
- R11: The timeout counter restarts at each accepted access, so time spent by an earlier access never shortens a later one.
- R12: After reset, `busy`, `rsp_valid`, `eng_cmd_valid` and `fault_latched` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, sampled while busy is low |
| req_ap | input | 1 | 1 selects an access-port register, 0 a debug-port register |
| req_rnw | input | 1 | 1 read, 0 write |
| req_addr | input | 2 | Register address bits 3:2 |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | An access is in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read data, 0 on failure or write |
| rsp_err | output | 1 | Access did not complete successfully |
| rsp_proto_err | output | 1 | Acknowledge code was not a legal value |
| fault_latched | output | 1 | Sticky fault status |
| eng_cmd_valid | output | 1 | Command offered to the engine |
| eng_cmd_ready | input | 1 | Engine takes the command |
| eng_cmd_ap | output | 1 | Command port select |
| eng_cmd_rnw | output | 1 | Command direction |
| eng_cmd_addr | output | 2 | Command register address bits 3:2 |
| eng_cmd_wdata | output | 32 | Command write data |
| eng_done | input | 1 | Engine finished the command |
| eng_ack | input | 3 | Acknowledge received from the target |
| eng_rdata | input | 32 | Read data received from the target |
| eng_rpar | input | 1 | Parity bit received with the read data |

## Verification
Properties watch every cycle for a held engine command that is unchanged until taken, a sticky fault status that never drops, and an immediate zero-data refusal of access-port requests while the fault is set. They also check that failed responses carry zero data, that illegal acknowledges leave the fault status alone, and that the controller is quiet after reset. How many times an access is retried, which abort masks appear on the engine port and in what order, and whether a WAIT storm ends on the timeout can only be shown by the bench. It scripts acknowledge sequences and compares the logged engine traffic and the response against its own model.

// File: rtl/swd_ctrl_pkg.sv
package swd_ctrl_pkg;
  localparam int DATA_W     = 32;
  localparam int REG_ADDR_W = 2;
  localparam int ACK_W      = 3;

  // acknowledge codes as seen on the wire (LSB first)
  localparam logic [ACK_W-1:0] ACK_OK     = 3'b001;
  localparam logic [ACK_W-1:0] ACK_WAIT   = 3'b010;
  localparam logic [ACK_W-1:0] ACK_FAULT  = 3'b100;
  localparam logic [ACK_W-1:0] ACK_NORESP = 3'b111;

  // abort register layout
  localparam int BIT_CANCEL  = 0;
  localparam int BIT_CMPCLR  = 1;
  localparam int BIT_ERRCLR  = 2;
  localparam int BIT_WDCLR   = 3;
  localparam int BIT_ORUNCLR = 4;
  localparam logic [REG_ADDR_W-1:0] ABORT_ADDR = '0;

  localparam logic [DATA_W-1:0] MASK_CANCEL = DATA_W'(1) << BIT_CANCEL;
  localparam logic [DATA_W-1:0] MASK_STICKY = (DATA_W'(1) << BIT_CMPCLR) |
                                              (DATA_W'(1) << BIT_ERRCLR) |
                                              (DATA_W'(1) << BIT_WDCLR)  |
                                              (DATA_W'(1) << BIT_ORUNCLR);

  typedef enum logic [2:0] {
    AK_OK, AK_WAIT, AK_FAULT, AK_NORESP, AK_BAD
  } ack_class_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_WAIT, ST_ABT_SEND, ST_ABT_WAIT
  } acc_state_e;

  typedef struct packed {
    logic                  ap;
    logic                  rnw;
    logic [REG_ADDR_W-1:0] addr;
    logic [DATA_W-1:0]     wdata;
  } swd_cmd_t;

  function automatic swd_cmd_t make_abort(input logic [DATA_W-1:0] mask);
    swd_cmd_t c;
    c.ap    = 1'b0;
    c.rnw   = 1'b0;
    c.addr  = ABORT_ADDR;
    c.wdata = mask;
    return c;
  endfunction
endpackage

// File: rtl/swd_ack_classify.sv
module swd_ack_classify
  import swd_ctrl_pkg::*;
(
  input  logic [ACK_W-1:0] ack,
  output ack_class_e       cls
);
  always_comb begin
    unique case (ack)
      ACK_OK:     cls = AK_OK;
      ACK_WAIT:   cls = AK_WAIT;
      ACK_FAULT:  cls = AK_FAULT;
      ACK_NORESP: cls = AK_NORESP;
      default:    cls = AK_BAD;
    endcase
  end
endmodule

// File: rtl/swd_parity_check.sv
module swd_parity_check #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] data,
  input  logic             par,
  output logic             bad
);
  // even parity over data plus parity bit
  assign bad = (^data) ^ par;
endmodule

// File: rtl/swd_access_timer.sv
module swd_access_timer #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (run && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == LIM);
endmodule

// File: rtl/swd_cmd_port.sv
module swd_cmd_port
  import swd_ctrl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  swd_cmd_t load_cmd,
  input  logic     ready,
  output logic     valid,
  output swd_cmd_t cmd,
  output logic     fire
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      cmd   <= '0;
    end else if (load) begin
      valid <= 1'b1;
      cmd   <= load_cmd;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  assign fire = valid && ready;
endmodule

// File: rtl/swd_access_ctrl.sv
module swd_access_ctrl
  import swd_ctrl_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 100000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_ap,
  input  logic                  req_rnw,
  input  logic [REG_ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  busy,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic                  rsp_err,
  output logic                  rsp_proto_err,
  output logic                  fault_latched,
  output logic                  eng_cmd_valid,
  input  logic                  eng_cmd_ready,
  output logic                  eng_cmd_ap,
  output logic                  eng_cmd_rnw,
  output logic [REG_ADDR_W-1:0] eng_cmd_addr,
  output logic [DATA_W-1:0]     eng_cmd_wdata,
  input  logic                  eng_done,
  input  logic [ACK_W-1:0]      eng_ack,
  input  logic [DATA_W-1:0]     eng_rdata,
  input  logic                  eng_rpar
);
  acc_state_e  st_q, st_d;
  swd_cmd_t    req_q, new_req, load_cmd, cur_cmd;
  logic        first_q, first_d;
  logic        retry_q, retry_d;
  logic        fault_q, fault_d;
  logic        load, start, fire, expired, par_bad;
  logic        fin, fin_err, fin_proto;
  logic [DATA_W-1:0] fin_data;
  ack_class_e  cls;

  swd_ack_classify u_cls (.ack(eng_ack), .cls(cls));

  swd_parity_check #(.WIDTH(DATA_W)) u_par (
    .data(eng_rdata), .par(eng_rpar), .bad(par_bad)
  );

  swd_access_timer #(.LIMIT(TIMEOUT_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .restart(start),
    .run(st_q != ST_IDLE), .expired(expired)
  );

  swd_cmd_port u_cmd (
    .clk(clk), .rst(rst), .load(load), .load_cmd(load_cmd),
    .ready(eng_cmd_ready), .valid(eng_cmd_valid), .cmd(cur_cmd), .fire(fire)
  );

  always_comb begin
    new_req.ap    = req_ap;
    new_req.rnw   = req_rnw;
    new_req.addr  = req_addr;
    new_req.wdata = req_wdata;
  end

  always_comb begin
    st_d      = st_q;
    first_d   = first_q;
    retry_d   = retry_q;
    fault_d   = fault_q;
    load      = 1'b0;
    load_cmd  = req_q;
    start     = 1'b0;
    fin       = 1'b0;
    fin_err   = 1'b0;
    fin_proto = 1'b0;
    fin_data  = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_ap && fault_q) begin
            fin     = 1'b1;
            fin_err = 1'b1;
          end else begin
            start    = 1'b1;
            first_d  = 1'b1;
            load     = 1'b1;
            load_cmd = new_req;
            st_d     = ST_SEND;
          end
        end
      end
      ST_SEND: if (fire) st_d = ST_WAIT;
      ST_WAIT: begin
        if (eng_done) begin
          unique case (cls)
            AK_OK: begin
              fin  = 1'b1;
              st_d = ST_IDLE;
              if (req_q.rnw) begin
                if (par_bad) begin
                  fault_d = 1'b1;
                  fin_err = 1'b1;
                end else begin
                  fin_data = eng_rdata;
                end
              end
            end
            AK_WAIT: begin
              load = 1'b1;
              if (expired) begin
                retry_d  = 1'b0;
                load_cmd = make_abort(MASK_CANCEL);
                st_d     = ST_ABT_SEND;
              end else begin
                st_d = ST_SEND;
              end
            end
            AK_FAULT: begin
              load     = 1'b1;
              retry_d  = first_q;
              first_d  = 1'b0;
              load_cmd = make_abort(MASK_STICKY);
              st_d     = ST_ABT_SEND;
            end
            AK_NORESP: begin
              fault_d = 1'b1;
              fin     = 1'b1;
              fin_err = 1'b1;
              st_d    = ST_IDLE;
            end
            default: begin
              fin       = 1'b1;
              fin_err   = 1'b1;
              fin_proto = 1'b1;
              st_d      = ST_IDLE;
            end
          endcase
        end
      end
      ST_ABT_SEND: if (fire) st_d = ST_ABT_WAIT;
      ST_ABT_WAIT: begin
        // acknowledge of the abort write itself is not examined
        if (eng_done) begin
          if (retry_q) begin
            load = 1'b1;
            if (expired) begin
              retry_d  = 1'b0;
              load_cmd = make_abort(MASK_CANCEL);
              st_d     = ST_ABT_SEND;
            end else begin
              st_d = ST_SEND;
            end
          end else begin
            fault_d = 1'b1;
            fin     = 1'b1;
            fin_err = 1'b1;
            st_d    = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_IDLE;
      req_q         <= '0;
      first_q       <= 1'b0;
      retry_q       <= 1'b0;
      fault_q       <= 1'b0;
      busy          <= 1'b0;
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      rsp_err       <= 1'b0;
      rsp_proto_err <= 1'b0;
    end else begin
      st_q          <= st_d;
      first_q       <= first_d;
      retry_q       <= retry_d;
      fault_q       <= fault_d;
      busy          <= (st_d != ST_IDLE);
      rsp_valid     <= fin;
      rsp_rdata     <= fin_data;
      rsp_err       <= fin_err;
      rsp_proto_err <= fin_proto;
      if (start) req_q <= new_req;
    end
  end

  assign fault_latched = fault_q;
  assign eng_cmd_ap    = cur_cmd.ap;
  assign eng_cmd_rnw   = cur_cmd.rnw;
  assign eng_cmd_addr  = cur_cmd.addr;
  assign eng_cmd_wdata = cur_cmd.wdata;
endmodule

// File: rtl/swd_access_ctrl_chk.sv
module swd_access_ctrl_chk
  import swd_ctrl_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic                  req_ap,
  input logic                  busy,
  input logic                  rsp_valid,
  input logic [DATA_W-1:0]     rsp_rdata,
  input logic                  rsp_err,
  input logic                  rsp_proto_err,
  input logic                  fault_latched,
  input logic                  eng_cmd_valid,
  input logic                  eng_cmd_ready,
  input logic                  eng_cmd_ap,
  input logic                  eng_cmd_rnw,
  input logic [REG_ADDR_W-1:0] eng_cmd_addr,
  input logic [DATA_W-1:0]     eng_cmd_wdata
);
  assert_reset_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !rsp_valid && !eng_cmd_valid && !fault_latched));

  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (eng_cmd_valid && !eng_cmd_ready) |=>
      (eng_cmd_valid && $stable(eng_cmd_ap) && $stable(eng_cmd_rnw) &&
       $stable(eng_cmd_addr) && $stable(eng_cmd_wdata)));

  assert_fault_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    fault_latched |=> fault_latched);

  assert_refuse_ap_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !rsp_valid && req_valid && req_ap && fault_latched) |=>
      (rsp_valid && rsp_err && rsp_rdata == '0 && !busy && !eng_cmd_valid));

  assert_fail_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

  assert_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_proto_nolatch_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_proto_err |-> (rsp_valid && rsp_err && $stable(fault_latched)));
endmodule

bind swd_access_ctrl swd_access_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ap(req_ap), .busy(busy),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
  .rsp_proto_err(rsp_proto_err), .fault_latched(fault_latched),
  .eng_cmd_valid(eng_cmd_valid), .eng_cmd_ready(eng_cmd_ready),
  .eng_cmd_ap(eng_cmd_ap), .eng_cmd_rnw(eng_cmd_rnw),
  .eng_cmd_addr(eng_cmd_addr), .eng_cmd_wdata(eng_cmd_wdata)
);

// File: tb/swd_access_ctrl_test.sv
module swd_access_ctrl_test;
  localparam int TMO = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_ap = 1'b0, req_rnw = 1'b0;
  logic [1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic busy, rsp_valid, rsp_err, rsp_proto_err, fault_latched;
  logic [31:0] rsp_rdata;
  logic eng_cmd_valid, eng_cmd_ap, eng_cmd_rnw;
  logic eng_cmd_ready = 1'b0;
  logic [1:0] eng_cmd_addr;
  logic [31:0] eng_cmd_wdata;
  logic eng_done = 1'b0, eng_rpar = 1'b0;
  logic [2:0] eng_ack = '0;
  logic [31:0] eng_rdata = '0;

  always #10 clk = ~clk;

  swd_access_ctrl #(.TIMEOUT_CYCLES(TMO)) uut (.*);

  int checks = 0, fails = 0;

  // acknowledge script and engine log
  logic [2:0]  scr[16];
  int          scr_len = 0;
  logic [2:0]  dflt = 3'b001;
  logic [31:0] rd_val = '0;
  bit          bad_par = 0;
  bit          fixed_mode = 0;
  int          att = 0;
  logic [35:0] log_q[64];
  int          n_log = 0;
  logic [35:0] exp_q[64];
  int          n_exp = 0;

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  // engine model, works on falling edges only
  initial begin
    int dly = 0;
    bit pend = 0;
    int stall = 0;
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      if (rst) begin
        pend = 0; eng_cmd_ready = 1'b0;
      end else if (pend) begin
        eng_cmd_ready = 1'b0;
        if (dly <= 1) begin
          pend = 0;
          eng_done = 1'b1;
        end else dly--;
      end else if (eng_cmd_valid) begin
        if (fixed_mode || $urandom_range(0, 3) != 0 || stall >= 2) begin
          logic [35:0] c;
          c = {eng_cmd_ap, eng_cmd_rnw, eng_cmd_addr, eng_cmd_wdata};
          eng_cmd_ready = 1'b1;
          stall = 0;
          pend = 1;
          dly = fixed_mode ? 3 : $urandom_range(1, 3);
          if (n_log < 64) log_q[n_log] = c;
          n_log++;
          if (!eng_cmd_ap && !eng_cmd_rnw && eng_cmd_addr == 2'b00) begin
            eng_ack = 3'b001; eng_rdata = '0; eng_rpar = 1'b0;
          end else begin
            eng_ack = (att < scr_len) ? scr[att] : dflt;
            att++;
            eng_rdata = rd_val;
            eng_rpar = (^rd_val) ^ bad_par;
          end
        end else begin
          eng_cmd_ready = 1'b0;
          stall++;
        end
      end else eng_cmd_ready = 1'b0;
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  logic [31:0] g_data;
  bit g_err, g_proto, g_fault, g_got;

  task automatic do_access(input bit ap, input bit rnw, input logic [1:0] a, input logic [31:0] wd);
    int n = 0;
    n_log = 0; att = 0; g_got = 0;
    @(negedge clk);
    req_valid = 1'b1; req_ap = ap; req_rnw = rnw; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && n < 2000) begin @(negedge clk); n++; end
    g_got = rsp_valid; g_data = rsp_rdata; g_err = rsp_err;
    g_proto = rsp_proto_err; g_fault = fault_latched;
  endtask

  // reference: expected engine traffic and response for the current script
  logic [31:0] e_data;
  bit e_err, e_proto, e_fault;

  task automatic predict(input bit ap, input bit rnw, input logic [1:0] a, input logic [31:0] wd);
    int k = 0;
    bit first = 1, fin = 0;
    logic [2:0] ak;
    n_exp = 0; e_data = '0; e_err = 0; e_proto = 0; e_fault = 0;
    while (!fin && n_exp < 60) begin
      ak = (k < scr_len) ? scr[k] : dflt;
      k++;
      exp_q[n_exp] = {ap, rnw, a, wd}; n_exp++;
      case (ak)
        3'b001: begin
          fin = 1;
          if (rnw && bad_par) begin e_err = 1; e_fault = 1; end
          else if (rnw) e_data = rd_val;
        end
        3'b010: ;
        3'b100: begin
          exp_q[n_exp] = {4'b0000, 32'h1E}; n_exp++;
          if (first) first = 0;
          else begin fin = 1; e_err = 1; e_fault = 1; end
        end
        3'b111: begin fin = 1; e_err = 1; e_fault = 1; end
        default: begin fin = 1; e_err = 1; e_proto = 1; end
      endcase
    end
  endtask

  task automatic compare(input string r);
    chk(g_got, r, g_got, 1);
    chk(g_data == e_data && g_err == e_err && g_proto == e_proto && g_fault == e_fault,
        r, {g_data, 28'd0, g_err, g_proto, g_fault, 1'b0}, {e_data, 28'd0, e_err, e_proto, e_fault, 1'b0});
    chk(n_log == n_exp, r, n_log, n_exp);
    for (int i = 0; i < n_exp && i < n_log; i++)
      chk(log_q[i] == exp_q[i], r, log_q[i], exp_q[i]);
  endtask

  task automatic run_case(input string r, input bit ap, input bit rnw, input logic [1:0] a, input logic [31:0] wd);
    predict(ap, rnw, a, wd);
    do_access(ap, rnw, a, wd);
    compare(r);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed_init;
    seed_init = $urandom(32'h5EED);
    do_reset();
    @(negedge clk);
    // R12 reset state
    chk(!busy && !rsp_valid && !eng_cmd_valid && !fault_latched, "R12",
        {busy, rsp_valid, eng_cmd_valid, fault_latched}, 0);

    // R1 plain read and write
    scr_len = 1; scr[0] = 3'b001; rd_val = 32'hCAFE_0123; bad_par = 0;
    run_case("R1 read ok", 1, 1, 2'b01, 32'h0);
    run_case("R1 write ok", 1, 0, 2'b11, 32'h1234_5678);

    // R2 wait retry
    scr_len = 3; scr[0] = 3'b010; scr[1] = 3'b010; scr[2] = 3'b001; rd_val = 32'h0F0F_0001;
    run_case("R2 wait retry", 0, 1, 2'b10, 32'h0);

    // R4 first fault cleared and retried
    scr_len = 2; scr[0] = 3'b100; scr[1] = 3'b001;
    run_case("R4 fault retry", 1, 0, 2'b01, 32'hA5A5_5A5A);

    // R5 second fault latches, then R8 refusal
    scr_len = 2; scr[0] = 3'b100; scr[1] = 3'b100;
    run_case("R5 double fault", 1, 1, 2'b00, 32'h0);
    do_access(1, 1, 2'b01, 32'h0);
    chk(g_got && g_err && g_data == 0 && n_log == 0, "R8 ap refused", {g_err, n_log[7:0]}, {1'b1, 8'd0});
    scr_len = 1; scr[0] = 3'b001; rd_val = 32'h2BA0_1477; e_fault = 1;
    do_access(0, 1, 2'b00, 32'h0);
    chk(g_got && !g_err && g_data == rd_val && n_log == 1, "R8 dp allowed", g_data, rd_val);
    do_reset();

    // R6 no response
    scr_len = 1; scr[0] = 3'b111;
    run_case("R6 no response", 1, 1, 2'b10, 32'h0);
    do_reset();

    // R7 illegal acknowledge
    scr_len = 1; scr[0] = 3'b011;
    run_case("R7 bad ack", 1, 0, 2'b10, 32'h77);
    chk(!fault_latched, "R7 no latch", fault_latched, 0);

    // R9 parity error
    scr_len = 1; scr[0] = 3'b001; rd_val = 32'h8000_0003; bad_par = 1;
    run_case("R9 parity", 1, 1, 2'b11, 32'h0);
    bad_par = 0;
    do_reset();

    // R3 wait storm ends in cancel abort
    scr_len = 0; dflt = 3'b010;
    do_access(1, 1, 2'b00, 32'h0);
    chk(g_got && g_err && g_fault && g_data == 0, "R3 timeout rsp", {g_err, g_fault}, 2'b11);
    chk(n_log >= 3 && n_log < 64 && log_q[n_log-1] == {4'b0000, 32'h1}, "R3 cancel abort",
        log_q[n_log-1], {4'b0000, 32'h1});
    chk(n_log >= 2 && log_q[n_log-2] == {1'b1, 1'b1, 2'b00, 32'h0}, "R3 last retry", log_q[n_log-2], 0);
    dflt = 3'b001;
    do_reset();

    // R11 timer restarts per access
    fixed_mode = 1;
    scr_len = 11; for (int i = 0; i < 10; i++) scr[i] = 3'b010; scr[10] = 3'b001;
    rd_val = 32'h0000_1111;
    run_case("R11 first", 0, 1, 2'b01, 32'h0);
    run_case("R11 second", 0, 1, 2'b01, 32'h0);
    fixed_mode = 0;

    // random mix
    for (int it = 0; it < 80; it++) begin
      logic [1:0] a;
      bit ap, rnw;
      scr_len = $urandom_range(1, 4);
      for (int j = 0; j < 16; j++) begin
        int p;
        p = $urandom_range(0, 9);
        if (j < scr_len - 1) scr[j] = (p < 7) ? 3'b010 : 3'b100;
        else scr[j] = (p < 5) ? 3'b001 : (p < 7) ? 3'b100 : (p < 8) ? 3'b111 : 3'b110;
      end
      rd_val = $urandom; bad_par = ($urandom_range(0, 9) == 0);
      ap = $urandom_range(0, 1); rnw = $urandom_range(0, 1); a = 2'($urandom_range(0, 3));
      if (!ap && !rnw && a == 2'b00) a = 2'b01;
      run_case("R1 R2 R4 R5 R6 R7 R9 random", ap, rnw, a, $urandom);
      if (fault_latched) do_reset();
    end
    bad_par = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule